// File: doc/BRIEF.md
# I2C Byte Service Handshake with Clock Stretching

This block sits between a CPU register port and an open-drain I2C bus. It takes part in transfers as a target. Each time a byte is complete and addressed to this node, it raises a one-cycle interrupt and clears a release flag. While that flag is clear, it holds SCL low, which stretches the bus clock until software has serviced the byte. Software releases the bus by reading or writing the data register, or by writing 1 to the flag. After that, SCL is let go a fixed number of system clock cycles later.

Address recognition can be switched on or off. When it is on, the first byte after a start condition is compared with a programmed 7-bit own address, and an all-zero byte is taken as a general call. A hit stretches the clock in the same way as a data byte. A miss makes the block ignore the rest of the transfer. When recognition is off, every byte after a start is serviced. A simple internal shifter moves the bits. It samples SDA on rising SCL and, in a read transfer, presents the data register MSB first. The byte format has no acknowledge slot. A 2-bit mode field enables the bus function. Any other value keeps both pins released.

Top module: `i2c_byte_hold`

## Requirements
- R1: After reset the release flag reads 1, the interrupt is low, and neither SCL nor SDA is driven.
- R2: The interrupt is a pulse of exactly one cycle. In every cycle it is high, the release flag reads 0.
- R3: While the mode field is 2'b10 and the release flag is 0, the block drives SCL low.
- R4: In a serviced transfer, every completed data byte (8 SCL rising edges, then the following SCL fall) raises the interrupt and clears the flag. The received byte can then be read on the data read port.
- R5: A data register read or write strobe sets the flag. SCL is then held for exactly RELEASE_DELAY further cycles and released after that.
- R6: With recognition on, a first byte after a start whose bits [7:1] equal the own address raises the interrupt and clears the flag. Its bit 0 is latched as the direction output (1 = the bus master reads from this block).
- R7: With recognition on, a first byte of 8'h00 (general call) raises the interrupt and clears the flag.
- R8: With recognition on, a first byte that matches neither raises no interrupt, and later bytes raise none until the next start.
- R9: With recognition off, every byte after a start, including the first, raises the interrupt and clears the flag.
- R10: Writing 1 through the flag write port sets the flag. Writing 0 leaves it unchanged.
- R11: With a mode field other than 2'b10, bus activity raises no interrupt and leaves the flag unchanged, and SCL and SDA stay released.
- R12: In a read-direction transfer, SDA carries the written data byte MSB first, one bit per SCL low period. SDA is released once that byte has been clocked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Operating mode; 2'b10 enables the bus function |
| addrMatchEn | input | 1 | 1 = address recognition on |
| ownAddr | input | DATA_BITS-1 | Own 7-bit target address |
| dataWrStb | input | 1 | Data register write strobe |
| dataWrData | input | DATA_BITS | Byte to transmit |
| dataRdStb | input | 1 | Data register read strobe |
| dataRdData | output | DATA_BITS | Last completed received byte |
| flagWrStb | input | 1 | Release flag write strobe |
| flagWrVal | input | 1 | Value written to the release flag (0 is ignored) |
| releaseFlag | output | 1 | Release flag; 0 = service pending |
| irqPulse | output | 1 | One-cycle service interrupt |
| rwDir | output | 1 | Direction bit of the matched address byte |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDriveLow | output | 1 | 1 = pull SCL low |
| sdaDriveLow | output | 1 | 1 = pull SDA low |

## Verification
The bound checker watches the flag and stretch rules on every cycle. It checks that the interrupt lasts one cycle and always coincides with a cleared flag, that SCL is pulled while service is pending in bus mode, that register accesses set the flag and the hold outlasts the set, that a zero write is inert, and that no interrupt appears outside bus mode. Only the bench scenarios can show address matching, general call, rejection of a foreign address, free-running mode, the exact release delay, the received byte value and the bit order on SDA, because these need real bus sequences driven through a wired-AND model.

// File: rtl/i2chs_pkg.sv
package i2chs_pkg;

  localparam logic [1:0] MODE_BUS = 2'b10;

  // events the bit engine reports to the control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic byteDone;
  } busEvt_t;

  // strobes the control hands to the bit engine
  typedef struct packed {
    logic busMode;
    logic txEnable;
    logic loadTx;
  } ctrlStb_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } busPhase_t;

endpackage

// File: rtl/i2chs_datapath.sv
module i2chs_datapath
  import i2chs_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  ctrlStb_t             stb,
  input  logic [DATA_BITS-1:0] txData,
  output busEvt_t              evt,
  output logic [DATA_BITS-1:0] rxShift,
  output logic [DATA_BITS-1:0] rxHeld,
  output logic                 sdaDriveLow
);

  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic                   sclNow;
  logic                   sdaNow;
  logic                   sclRise;
  logic                   sclFall;
  logic [CNT_W-1:0]       bitCnt;
  logic [DATA_BITS-1:0]   txShift;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // line synchronizers, idle bus is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    sclRise       = stb.busMode & sclNow & ~sclPrev;
    sclFall       = stb.busMode & ~sclNow & sclPrev;
    evt.startSeen = stb.busMode & sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopSeen  = stb.busMode & sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.byteDone  = sclFall && (bitCnt == LAST_BIT);
  end

  // receive shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      rxHeld  <= '0;
    end else if (evt.startSeen || evt.stopSeen) begin
      bitCnt <= '0;
    end else if (sclRise && (bitCnt != LAST_BIT)) begin
      rxShift <= {rxShift[DATA_BITS-2:0], sdaNow};
      bitCnt  <= bitCnt + CNT_W'(1);
    end else if (evt.byteDone) begin
      bitCnt <= '0;
      rxHeld <= rxShift;
    end
  end

  // transmit shifter, refills with ones so SDA ends released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (stb.loadTx) begin
      txShift <= txData;
    end else if (sclFall && stb.txEnable && (bitCnt != '0)) begin
      txShift <= {txShift[DATA_BITS-2:0], 1'b1};
    end
  end

  assign sdaDriveLow = stb.busMode & stb.txEnable & ~txShift[DATA_BITS-1];

endmodule

// File: rtl/i2chs_control.sv
module i2chs_control
  import i2chs_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int RELEASE_DELAY = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic                 addrMatchEn,
  input  logic [DATA_BITS-2:0] ownAddr,
  input  logic                 dataWrStb,
  input  logic                 dataRdStb,
  input  logic                 flagWrStb,
  input  logic                 flagWrVal,
  input  busEvt_t              evt,
  input  logic [DATA_BITS-1:0] rxShift,
  output ctrlStb_t             stb,
  output logic                 releaseFlag,
  output logic                 irqPulse,
  output logic                 rwDir,
  output logic                 sclDriveLow
);

  localparam int HOLD_W = (RELEASE_DELAY < 1) ? 1 : $clog2(RELEASE_DELAY + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RELEASE_DELAY);

  busPhase_t         phase;
  logic              busMode;
  logic              addrHit;
  logic              byteHit;
  logic              swSet;
  logic [HOLD_W-1:0] holdCnt;

  always_comb begin
    busMode = (modeSel == MODE_BUS);
    addrHit = (rxShift[DATA_BITS-1:1] == ownAddr) || (rxShift == '0);
    swSet   = dataWrStb | dataRdStb | (flagWrStb & flagWrVal);
    byteHit = 1'b0;
    if (evt.byteDone) begin
      case (phase)
        PH_ADDR: byteHit = addrHit;
        PH_DATA: byteHit = 1'b1;
        default: byteHit = 1'b0;
      endcase
    end
  end

  // release flag, interrupt and hold timer; a serviced byte beats a set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      releaseFlag <= 1'b1;
      irqPulse    <= 1'b0;
      holdCnt     <= '0;
    end else begin
      irqPulse <= byteHit;
      if (byteHit) begin
        releaseFlag <= 1'b0;
        holdCnt     <= '0;
      end else if (swSet) begin
        releaseFlag <= 1'b1;
        if (!releaseFlag) holdCnt <= HOLD_LOAD;
        else if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - HOLD_W'(1);
      end
    end
  end

  // transfer phase tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      rwDir <= 1'b0;
    end else if (!busMode) begin
      phase <= PH_IDLE;
      rwDir <= 1'b0;
    end else if (evt.startSeen) begin
      phase <= addrMatchEn ? PH_ADDR : PH_DATA;
      rwDir <= 1'b0;
    end else if (evt.stopSeen) begin
      phase <= PH_IDLE;
      rwDir <= 1'b0;
    end else if (evt.byteDone && (phase == PH_ADDR)) begin
      if (addrHit) begin
        phase <= PH_DATA;
        rwDir <= rxShift[0];
      end else begin
        phase <= PH_SKIP;
      end
    end
  end

  always_comb begin
    stb.busMode  = busMode;
    stb.txEnable = (phase == PH_DATA) && rwDir;
    stb.loadTx   = dataWrStb;
    sclDriveLow  = busMode & (~releaseFlag | (holdCnt != '0));
  end

endmodule

// File: rtl/i2c_byte_hold.sv
module i2c_byte_hold
  import i2chs_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int RELEASE_DELAY = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           modeSel,
  input  logic                 addrMatchEn,
  input  logic [DATA_BITS-2:0] ownAddr,
  input  logic                 dataWrStb,
  input  logic [DATA_BITS-1:0] dataWrData,
  input  logic                 dataRdStb,
  output logic [DATA_BITS-1:0] dataRdData,
  input  logic                 flagWrStb,
  input  logic                 flagWrVal,
  output logic                 releaseFlag,
  output logic                 irqPulse,
  output logic                 rwDir,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclDriveLow,
  output logic                 sdaDriveLow
);

  busEvt_t              evt;
  ctrlStb_t             stb;
  logic [DATA_BITS-1:0] rxShift;

  i2chs_datapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .stb        (stb),
    .txData     (dataWrData),
    .evt        (evt),
    .rxShift    (rxShift),
    .rxHeld     (dataRdData),
    .sdaDriveLow(sdaDriveLow)
  );

  i2chs_control #(
    .DATA_BITS    (DATA_BITS),
    .RELEASE_DELAY(RELEASE_DELAY)
  ) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .addrMatchEn(addrMatchEn),
    .ownAddr    (ownAddr),
    .dataWrStb  (dataWrStb),
    .dataRdStb  (dataRdStb),
    .flagWrStb  (flagWrStb),
    .flagWrVal  (flagWrVal),
    .evt        (evt),
    .rxShift    (rxShift),
    .stb        (stb),
    .releaseFlag(releaseFlag),
    .irqPulse   (irqPulse),
    .rwDir      (rwDir),
    .sclDriveLow(sclDriveLow)
  );

endmodule

// File: rtl/i2c_byte_hold_chk.sv
module i2c_byte_hold_chk
  import i2chs_pkg::*;
#(
  parameter int RELEASE_DELAY = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       dataWrStb,
  input logic       dataRdStb,
  input logic       flagWrStb,
  input logic       flagWrVal,
  input logic       releaseFlag,
  input logic       irqPulse,
  input logic       sclDriveLow
);

  AST_IRQ_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !releaseFlag); // R2

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R2

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == MODE_BUS) && !releaseFlag) |-> sclDriveLow); // R3

  AST_ACCESS_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrStb || dataRdStb) |=> (releaseFlag || irqPulse)); // R5

  AST_HOLD_ON_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((RELEASE_DELAY > 0) && (modeSel == MODE_BUS) && $rose(releaseFlag)) |-> sclDriveLow); // R5

  AST_ZERO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrStb && !flagWrVal && !dataWrStb && !dataRdStb && !releaseFlag) |=> !releaseFlag); // R10

  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_BUS) |=> !irqPulse); // R11

endmodule

bind i2c_byte_hold i2c_byte_hold_chk #(.RELEASE_DELAY(RELEASE_DELAY)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .modeSel    (modeSel),
  .dataWrStb  (dataWrStb),
  .dataRdStb  (dataRdStb),
  .flagWrStb  (flagWrStb),
  .flagWrVal  (flagWrVal),
  .releaseFlag(releaseFlag),
  .irqPulse   (irqPulse),
  .sclDriveLow(sclDriveLow)
);

// File: tb/i2c_byte_hold_test.sv
`timescale 1ns/1ps
module i2c_byte_hold_test;

  localparam int DELAY = 4;
  localparam int HALF  = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] modeSel;
  logic       addrMatchEn;
  logic [6:0] ownAddr;
  logic       dataWrStb;
  logic [7:0] dataWrData;
  logic       dataRdStb;
  logic [7:0] dataRdData;
  logic       flagWrStb;
  logic       flagWrVal;
  logic       releaseFlag;
  logic       irqPulse;
  logic       rwDir;
  logic       sclDriveLow;
  logic       sdaDriveLow;
  logic       sclMaster;
  logic       sdaMaster;
  logic       sclLine;
  logic       sdaLine;

  int total = 0;
  int bad = 0;
  int irqCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND bus
  assign sclLine = sclMaster & ~sclDriveLow;
  assign sdaLine = sdaMaster & ~sdaDriveLow;

  i2c_byte_hold #(.DATA_BITS(8), .RELEASE_DELAY(DELAY), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .addrMatchEn(addrMatchEn),
    .ownAddr(ownAddr), .dataWrStb(dataWrStb), .dataWrData(dataWrData),
    .dataRdStb(dataRdStb), .dataRdData(dataRdData), .flagWrStb(flagWrStb),
    .flagWrVal(flagWrVal), .releaseFlag(releaseFlag), .irqPulse(irqPulse),
    .rwDir(rwDir), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle monitors: R2 flag low with interrupt, R3 SCL held while pending
  always @(negedge clk) begin
    if (rstN) begin
      if (irqPulse) irqCount++;
      if (irqPulse) check("R2 flag during irq", releaseFlag, 0);
      if (modeSel == 2'b10 && !releaseFlag) check("R3 scl line while pending", sclLine, 0);
    end
  end

  task automatic busWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclRaise();
    sclMaster = 1'b1;
    for (int k = 0; k < 500; k++) begin
      if (sclLine) break;
      @(negedge clk);
    end
    if (!sclLine) check("R5 scl never released", sclLine, 1);
  endtask

  task automatic sendStart();
    sdaMaster = 1'b1; busWait(HALF);
    sclRaise(); busWait(HALF);
    sdaMaster = 1'b0; busWait(HALF);
    sclMaster = 1'b0; busWait(HALF);
  endtask

  task automatic sendStop();
    sclMaster = 1'b0; sdaMaster = 1'b0; busWait(HALF);
    sclRaise(); busWait(HALF);
    sdaMaster = 1'b1; busWait(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaMaster = b[i]; busWait(HALF);
      sclRaise(); busWait(HALF);
      sclMaster = 1'b0;
    end
    busWait(HALF);
  endtask

  task automatic readByte(output logic [7:0] b);
    sdaMaster = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      busWait(HALF);
      sclRaise(); busWait(HALF / 2);
      b[i] = sdaLine;
      busWait(HALF / 2);
      sclMaster = 1'b0;
    end
    busWait(HALF);
  endtask

  task automatic cpuRead(output logic [7:0] v);
    @(negedge clk); dataRdStb = 1'b1; v = dataRdData;
    @(negedge clk); dataRdStb = 1'b0;
  endtask

  task automatic cpuWrite(input logic [7:0] v);
    @(negedge clk); dataWrStb = 1'b1; dataWrData = v;
    @(negedge clk); dataWrStb = 1'b0;
  endtask

  task automatic flagWrite(input logic v);
    @(negedge clk); flagWrStb = 1'b1; flagWrVal = v;
    @(negedge clk); flagWrStb = 1'b0;
  endtask

  task automatic testReset();
    check("R1 flag after reset", releaseFlag, 1);
    check("R1 irq after reset", irqPulse, 0);
    check("R1 scl drive after reset", sclDriveLow, 0);
    check("R1 sda drive after reset", sdaDriveLow, 0);
  endtask

  task automatic testMatchWrite();
    int base;
    int n;
    logic [7:0] v;
    sendStart();
    base = irqCount;
    sendByte({OWN, 1'b0});
    check("R6 irq on own address", irqCount - base, 1);
    check("R6 flag cleared on match", releaseFlag, 0);
    check("R6 direction write", rwDir, 0);
    check("R3 scl driven while pending", sclDriveLow, 1);
    flagWrite(1'b0); busWait(4);
    check("R10 zero write keeps flag", releaseFlag, 0);
    check("R10 scl still held", sclDriveLow, 1);
    cpuRead(v);
    check("R5 read sets flag", releaseFlag, 1);
    n = 0;
    while (sclDriveLow && n < 50) begin n++; @(negedge clk); end
    check("R5 release delay", n, DELAY);
    base = irqCount;
    sendByte(8'hC3);
    check("R4 irq on data byte", irqCount - base, 1);
    check("R4 flag cleared on data byte", releaseFlag, 0);
    cpuRead(v);
    check("R4 received byte", v, 8'hC3);
    base = irqCount;
    sendByte(8'h5E);
    check("R4 second data byte irq", irqCount - base, 1);
    flagWrite(1'b1); busWait(DELAY + 2);
    check("R10 one write sets flag", releaseFlag, 1);
    check("R10 scl released after write", sclDriveLow, 0);
    sendStop();
  endtask

  task automatic testGeneralCall();
    int base;
    sendStart();
    base = irqCount;
    sendByte(8'h00);
    check("R7 general call irq", irqCount - base, 1);
    check("R7 general call flag", releaseFlag, 0);
    flagWrite(1'b1); busWait(DELAY + 2);
    sendStop();
  endtask

  task automatic testMismatch();
    int base;
    sendStart();
    base = irqCount;
    sendByte(8'h55);
    check("R8 no irq on foreign address", irqCount - base, 0);
    check("R8 flag kept on foreign address", releaseFlag, 1);
    sendByte(8'h11);
    check("R8 later byte ignored", irqCount - base, 0);
    check("R8 scl not held", sclDriveLow, 0);
    sendStop();
  endtask

  task automatic testFreeMode();
    int base;
    addrMatchEn = 1'b0;
    sendStart();
    base = irqCount;
    sendByte(8'h55);
    check("R9 first byte serviced", irqCount - base, 1);
    check("R9 flag cleared", releaseFlag, 0);
    flagWrite(1'b1); busWait(DELAY + 2);
    sendStop();
    addrMatchEn = 1'b1;
  endtask

  task automatic testTransmit();
    int base;
    logic [7:0] rb;
    sendStart();
    base = irqCount;
    sendByte({OWN, 1'b1});
    check("R6 direction read", rwDir, 1);
    check("R6 irq on read address", irqCount - base, 1);
    cpuWrite(8'hA5);
    check("R5 write sets flag", releaseFlag, 1);
    base = irqCount;
    readByte(rb);
    check("R12 transmitted byte", rb, 8'hA5);
    check("R4 irq after sent byte", irqCount - base, 1);
    check("R12 sda released after byte", sdaDriveLow, 0);
    flagWrite(1'b1); busWait(DELAY + 2);
    sendStop();
  endtask

  task automatic testModeOff();
    int base;
    modeSel = 2'b01;
    busWait(2);
    sendStart();
    base = irqCount;
    sendByte({OWN, 1'b0});
    check("R11 no irq when off", irqCount - base, 0);
    check("R11 flag kept when off", releaseFlag, 1);
    check("R11 scl released when off", sclDriveLow, 0);
    check("R11 sda released when off", sdaDriveLow, 0);
    sendStop();
    modeSel = 2'b10;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; modeSel = 2'b10; addrMatchEn = 1'b1; ownAddr = OWN;
    dataWrStb = 1'b0; dataWrData = 8'h00; dataRdStb = 1'b0;
    flagWrStb = 1'b0; flagWrVal = 1'b0; sclMaster = 1'b1; sdaMaster = 1'b1;
    busWait(5);
    rstN = 1'b1;
    busWait(5);
    testReset();
    testMatchWrite();
    testGeneralCall();
    testMismatch();
    testFreeMode();
    testTransmit();
    testModeOff();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule